// File: doc/BRIEF.md
# Receive Frame Length Supervisor

This block sits on a receive byte stream, one byte per valid cycle, with start and end markers. It counts the bytes of each frame and makes two separate decisions. The first is whether the frame is oversize (giant). The second is whether the stream must be cut off because a length watchdog expired. Bytes up to the cut-off point are forwarded one cycle later, unchanged. Bytes past that point are dropped. The last forwarded byte always carries an end marker.

Four configuration inputs choose the limits: a jumbo enable, a 2K-packet enable, a watchdog disable and a VLAN-tagged flag. The tag flag is supplied by an upstream parser. The block samples these inputs on the start byte of each frame. Two status flags report the outcome of the most recent frame: giant and truncated.

Top module: `rx_len_guard`

## Requirements
- R1: With jumbo off and 2K mode off, a frame is flagged giant when its length exceeds 1518 bytes, or 1522 bytes when the tag flag is set.
- R2: With jumbo off and 2K mode on, frames of up to 2000 bytes are not giant, and longer frames are giant, whatever the tag flag is.
- R3: With jumbo on, the giant limit is 9018 bytes (9022 when tagged), whatever the 2K mode input is.
- R4: With the watchdog active, only the first 2048 bytes (10240 with jumbo on) are forwarded. The last forwarded byte carries an end marker, and later bytes of that frame produce no output. The truncated flag is set and implies the giant flag.
- R5: With the watchdog disabled, the cut-off point moves to 16384 bytes.
- R6: A frame whose input end marker falls exactly on the cut-off byte is not truncated. A one-byte frame (start and end markers on the same byte) is forwarded with both markers and gets its own flags.
- R7: A start marker inside a frame aborts that frame. Its forwarded bytes end without an end marker, and counting restarts from 1 on the new start byte.
- R8: Mode inputs are captured on the start byte. Changing them in the middle of a frame does not alter that frame's limits.
- R9: A valid byte that arrives outside a frame without a start marker is ignored: it produces no output and leaves the flags unchanged.
- R10: The flags update in the cycle after the input end marker is accepted. They then hold until the cycle after the next start byte, which clears them unless that byte also ends its frame.
- R11: The length count is 15 bits wide and saturates at 32767. A frame longer than the count range therefore still reads as giant and truncated.
- R12: A forwarded byte appears one cycle after it is accepted, with the same data, and carries a start marker exactly when the input byte did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is first of a frame |
| in_eop | input | 1 | Input byte is last of a frame |
| in_data | input | 8 | Input byte |
| cfg_jumbo | input | 1 | Jumbo limits enable |
| cfg_twok | input | 1 | 2K-packet limit enable |
| cfg_wdog_off | input | 1 | Watchdog cut-off disable (16384-byte limit) |
| cfg_tagged | input | 1 | Current frame carries a VLAN tag |
| out_valid | output | 1 | Forwarded byte valid |
| out_sop | output | 1 | Forwarded byte is first of a frame |
| out_eop | output | 1 | Forwarded byte is last forwarded byte of a frame |
| out_data | output | 8 | Forwarded byte |
| stat_giant | output | 1 | Last completed frame exceeded the giant limit |
| stat_trunc | output | 1 | Last completed frame was cut at the watchdog limit |

## Verification
The watchdog cut-off and the input end marker can fall on the same byte. In that cycle the block must emit one end marker and must not report truncation. The bench provokes this with frames of exactly 2048 bytes and of 2049 and 2050 bytes. The scoreboard then judges the marker position, and the flag checks judge whether truncation is reported. A start marker and an end marker on one byte is a second coincidence. It is driven with a one-byte frame, which must be forwarded with both markers and get fresh flags.

// File: rtl/rfl_pkg.sv
package rfl_pkg;

   typedef struct packed {
      logic       sop;
      logic       eop;
      logic [7:0] data;
   } rfl_beat_t;

   typedef enum logic [1:0] {
      MODE_STD   = 2'd0,
      MODE_TWOK  = 2'd1,
      MODE_JUMBO = 2'd2
   } rfl_mode_e;

endpackage

// File: rtl/rfl_limit_sel.sv
module rfl_limit_sel
   import rfl_pkg::*;
#(
   parameter int LEN_W      = 15,
   parameter int STD_MAX    = 1518,
   parameter int TAG_EXTRA  = 4,
   parameter int TWOK_MAX   = 2000,
   parameter int JUMBO_MAX  = 9018,
   parameter int WD_STD     = 2048,
   parameter int WD_JUMBO   = 10240,
   parameter int WD_OFF     = 16384
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic             cfg_jumbo,
   input  logic             cfg_twok,
   input  logic             cfg_wdog_off,
   input  logic             cfg_tagged,
   output logic [LEN_W-1:0] giant_lim,
   output logic [LEN_W-1:0] cut_lim
);

   localparam logic [LEN_W-1:0] L_STD     = LEN_W'(STD_MAX);
   localparam logic [LEN_W-1:0] L_STD_T   = LEN_W'(STD_MAX + TAG_EXTRA);
   localparam logic [LEN_W-1:0] L_TWOK    = LEN_W'(TWOK_MAX);
   localparam logic [LEN_W-1:0] L_JUMBO   = LEN_W'(JUMBO_MAX);
   localparam logic [LEN_W-1:0] L_JUMBO_T = LEN_W'(JUMBO_MAX + TAG_EXTRA);
   localparam logic [LEN_W-1:0] C_STD     = LEN_W'(WD_STD);
   localparam logic [LEN_W-1:0] C_JUMBO   = LEN_W'(WD_JUMBO);
   localparam logic [LEN_W-1:0] C_OFF     = LEN_W'(WD_OFF);

   rfl_mode_e        mode;
   logic [LEN_W-1:0] live_giant, live_cut;
   logic [LEN_W-1:0] held_giant, held_cut;

   always_comb begin
      if (cfg_jumbo)     mode = MODE_JUMBO;
      else if (cfg_twok) mode = MODE_TWOK;
      else               mode = MODE_STD;
   end

   always_comb begin
      unique case (mode)
         MODE_JUMBO: live_giant = cfg_tagged ? L_JUMBO_T : L_JUMBO;
         MODE_TWOK:  live_giant = L_TWOK;
         default:    live_giant = cfg_tagged ? L_STD_T : L_STD;
      endcase
   end

   always_comb begin
      if (cfg_wdog_off)              live_cut = C_OFF;
      else if (mode == MODE_JUMBO)   live_cut = C_JUMBO;
      else                           live_cut = C_STD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_giant <= L_STD;
         held_cut   <= C_STD;
      end else if (capture) begin
         held_giant <= live_giant;
         held_cut   <= live_cut;
      end
   end

   assign giant_lim = capture ? live_giant : held_giant;
   assign cut_lim   = capture ? live_cut   : held_cut;

   // R4
   cut_above_giant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cut_lim >= giant_lim);

endmodule

// File: rtl/rfl_len_cnt.sv
module rfl_len_cnt #(
   parameter int LEN_W  = 15,
   parameter bit SAT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   output logic [LEN_W-1:0] len_now
);

   localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);
   localparam logic [LEN_W-1:0] TOP_V = {LEN_W{1'b1}};

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] inc_v;

   generate
      if (SAT_EN) begin : g_sat
         assign inc_v = (cnt_q == TOP_V) ? TOP_V : cnt_q + ONE;
      end else begin : g_wrap
         assign inc_v = cnt_q + ONE;
      end
   endgenerate

   assign len_now = restart ? ONE : inc_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (step)  cnt_q <= len_now;
   end

   generate
      if (SAT_EN) begin : g_sat_chk
         // R11
         len_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !restart) |=> (cnt_q >= $past(cnt_q)));
      end
   endgenerate

endmodule

// File: rtl/rfl_fwd_reg.sv
module rfl_fwd_reg
   import rfl_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      vld_i,
   input  rfl_beat_t beat_i,
   output logic      vld_o,
   output rfl_beat_t beat_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         beat_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) beat_o <= beat_i;
      end
   end

endmodule

// File: rtl/rx_len_guard.sv
module rx_len_guard
   import rfl_pkg::*;
#(
   parameter int LEN_W     = 15,
   parameter bit SAT_EN    = 1'b1,
   parameter int STD_MAX   = 1518,
   parameter int TAG_EXTRA = 4,
   parameter int TWOK_MAX  = 2000,
   parameter int JUMBO_MAX = 9018,
   parameter int WD_STD    = 2048,
   parameter int WD_JUMBO  = 10240,
   parameter int WD_OFF    = 16384
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       in_sop,
   input  logic       in_eop,
   input  logic [7:0] in_data,
   input  logic       cfg_jumbo,
   input  logic       cfg_twok,
   input  logic       cfg_wdog_off,
   input  logic       cfg_tagged,
   output logic       out_valid,
   output logic       out_sop,
   output logic       out_eop,
   output logic [7:0] out_data,
   output logic       stat_giant,
   output logic       stat_trunc
);

   localparam int LEN_MAX = (1 << LEN_W) - 1;

   initial begin
      par_width_chk: assert (WD_OFF <= LEN_MAX && WD_JUMBO <= LEN_MAX)
         else $error("LEN_W too small for cut-off limits");
      par_order_chk: assert (WD_STD >= STD_MAX + TAG_EXTRA && WD_STD >= TWOK_MAX
                             && WD_JUMBO >= JUMBO_MAX + TAG_EXTRA && WD_OFF >= WD_JUMBO)
         else $error("cut-off limits must not be below giant limits");
   end

   logic             in_frame_q;
   logic             giant_q, trunc_q;
   logic             acc, acc_sop, end_evt, fwd, at_cut;
   logic [LEN_W-1:0] len_now, giant_lim, cut_lim;
   rfl_beat_t        beat_in, beat_out;
   logic             vld_out;

   assign acc     = in_valid && (in_sop || in_frame_q);
   assign acc_sop = acc && in_sop;
   assign end_evt = acc && in_eop;

   rfl_limit_sel #(
      .LEN_W(LEN_W), .STD_MAX(STD_MAX), .TAG_EXTRA(TAG_EXTRA),
      .TWOK_MAX(TWOK_MAX), .JUMBO_MAX(JUMBO_MAX),
      .WD_STD(WD_STD), .WD_JUMBO(WD_JUMBO), .WD_OFF(WD_OFF)
   ) u_lim (
      .clk(clk), .rst_n(rst_n), .capture(acc_sop),
      .cfg_jumbo(cfg_jumbo), .cfg_twok(cfg_twok),
      .cfg_wdog_off(cfg_wdog_off), .cfg_tagged(cfg_tagged),
      .giant_lim(giant_lim), .cut_lim(cut_lim)
   );

   rfl_len_cnt #(.LEN_W(LEN_W), .SAT_EN(SAT_EN)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(acc), .restart(in_sop), .len_now(len_now)
   );

   assign fwd    = acc && (len_now <= cut_lim);
   assign at_cut = (len_now == cut_lim);

   always_comb begin
      beat_in.sop  = in_sop;
      beat_in.eop  = in_eop || at_cut;
      beat_in.data = in_data;
   end

   rfl_fwd_reg u_out (
      .clk(clk), .rst_n(rst_n), .vld_i(fwd), .beat_i(beat_in),
      .vld_o(vld_out), .beat_o(beat_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         giant_q    <= 1'b0;
         trunc_q    <= 1'b0;
      end else begin
         if (end_evt)      in_frame_q <= 1'b0;
         else if (acc_sop) in_frame_q <= 1'b1;

         if (end_evt) begin
            giant_q <= (len_now > giant_lim);
            trunc_q <= (len_now > cut_lim);
         end else if (acc_sop) begin
            giant_q <= 1'b0;
            trunc_q <= 1'b0;
         end
      end
   end

   assign out_valid  = vld_out;
   assign out_sop    = vld_out && beat_out.sop;
   assign out_eop    = vld_out && beat_out.eop;
   assign out_data   = beat_out.data;
   assign stat_giant = giant_q;
   assign stat_trunc = trunc_q;

   // R10
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_sop || end_evt) |=> ($stable(stat_giant) && $stable(stat_trunc)));

   // R9
   stray_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_sop && !in_frame_q) |=> !out_valid);

   // R4
   trunc_giant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_trunc |-> stat_giant);

   // R4
   cut_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_eop)) |-> out_sop);

endmodule

// File: tb/tb_rx_len_guard.sv
module tb_rx_len_guard;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [7:0] in_data = '0;
   logic       cfg_jumbo = 1'b0, cfg_twok = 1'b0, cfg_wdog_off = 1'b0, cfg_tagged = 1'b0;
   logic       out_valid, out_sop, out_eop, stat_giant, stat_trunc;
   logic [7:0] out_data;

   int total = 0;
   int bad   = 0;
   logic [9:0] expq[$];

   always #2 clk = ~clk;

   rx_len_guard dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_data(in_data), .cfg_jumbo(cfg_jumbo),
      .cfg_twok(cfg_twok), .cfg_wdog_off(cfg_wdog_off), .cfg_tagged(cfg_tagged),
      .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
      .out_data(out_data), .stat_giant(stat_giant), .stat_trunc(stat_trunc)
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: R12 every forwarded beat matches the scoreboard head
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (expq.size() == 0) check("R9/R12 unexpected beat", {out_sop, out_eop, out_data}, -1);
         else check("R12 beat", {out_sop, out_eop, out_data}, expq.pop_front());
      end
   end

   function automatic int giant_limit(bit j, bit t, bit tag);
      if (j) return tag ? 9022 : 9018;
      if (t) return 2000;
      return tag ? 1522 : 1518;
   endfunction

   function automatic int cut_limit(bit j, bit w);
      if (w) return 16384;
      return j ? 10240 : 2048;
   endfunction

   task automatic set_cfg(bit j, bit t, bit w, bit tag);
      cfg_jumbo = j; cfg_twok = t; cfg_wdog_off = w; cfg_tagged = tag;
   endtask

   task automatic send_frame(string req, int len, bit noeop, int flip_at);
      int  gl  = giant_limit(cfg_jumbo, cfg_twok, cfg_tagged);
      int  cl  = cut_limit(cfg_jumbo, cfg_wdog_off);
      int  sl  = (len > 32767) ? 32767 : len;
      for (int i = 1; i <= len; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sop   = (i == 1);
         in_eop   = (i == len) && !noeop;
         in_data  = 8'(i * 7 + len);
         if (i == flip_at) cfg_jumbo = ~cfg_jumbo;
         if (i <= cl)
            expq.push_back({in_sop, (in_eop || i == cl), in_data});
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      if (!noeop) begin
         check({req, " giant"}, stat_giant, sl > gl);
         check({req, " trunc"}, stat_trunc, sl > cl);
      end
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      check("watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset out_valid", out_valid, 0);
      check("R10 reset giant", stat_giant, 0);
      check("R10 reset trunc", stat_trunc, 0);
      rst_n = 1'b1;
      @(negedge clk);

      set_cfg(0, 0, 0, 0);
      send_frame("R1 64", 64, 0, 0);
      send_frame("R1 1518", 1518, 0, 0);
      send_frame("R1 1519", 1519, 0, 0);
      cfg_tagged = 1;
      send_frame("R1 tag 1522", 1522, 0, 0);
      send_frame("R1 tag 1523", 1523, 0, 0);

      set_cfg(0, 1, 0, 1);
      send_frame("R2 2000", 2000, 0, 0);
      send_frame("R2 2001", 2001, 0, 0);

      set_cfg(1, 1, 0, 0);
      send_frame("R3 9018 twok on", 9018, 0, 0);
      set_cfg(1, 0, 0, 0);
      send_frame("R3 9019", 9019, 0, 0);
      cfg_tagged = 1;
      send_frame("R3 tag 9023", 9023, 0, 0);

      set_cfg(0, 0, 0, 0);
      send_frame("R6 exact cut 2048", 2048, 0, 0);
      send_frame("R4 2049", 2049, 0, 0);
      send_frame("R4 2050", 2050, 0, 0);
      set_cfg(1, 0, 0, 0);
      send_frame("R4 jumbo 10245", 10245, 0, 0);

      set_cfg(0, 0, 1, 0);
      send_frame("R5 3000", 3000, 0, 0);
      send_frame("R5 16390", 16390, 0, 0);

      set_cfg(0, 0, 0, 0);
      send_frame("R6 one byte", 1, 0, 0);

      // R7: aborted frame then new frame
      send_frame("R7 aborted", 10, 1, 0);
      send_frame("R7 after abort", 20, 0, 0);

      // R8: jumbo dropped mid-frame, limits stay jumbo
      set_cfg(1, 0, 0, 0);
      send_frame("R8 cfg change", 3000, 0, 100);
      check("R8 cfg flipped", cfg_jumbo, 0);

      // R10/R9: giant frame, then idle and stray bytes, flags must hold
      set_cfg(0, 0, 0, 0);
      send_frame("R10 giant", 1600, 0, 0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sop = 1'b0; in_eop = (k == 3); in_data = 8'hA5;
      end
      @(negedge clk);
      in_valid = 1'b0; in_eop = 1'b0;
      @(negedge clk);
      check("R9 stray no output", expq.size(), 0);
      check("R10 giant held", stat_giant, 1);
      // next start byte clears flags one cycle later
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b1; in_data = 8'h11;
      expq.push_back({1'b1, 1'b0, 8'h11});
      @(negedge clk);
      in_sop = 1'b0; in_eop = 1'b1; in_data = 8'h22;
      expq.push_back({1'b0, 1'b1, 8'h22});
      check("R10 cleared on sop", stat_giant, 0);
      @(negedge clk);
      in_valid = 1'b0; in_eop = 1'b0;
      check("R10 short frame giant", stat_giant, 0);

      // R11: saturating count
      set_cfg(0, 0, 1, 0);
      send_frame("R11 saturate 32800", 32800, 0, 0);

      repeat (4) @(negedge clk);
      check("R12 scoreboard drained", expq.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule